// File: doc/BRIEF.md
# Narrow-Region Access Splitter with Bus Lock

This block sits between a 32-bit internal bus master and a group of slave regions that are narrower than the master. Each region is either 8 or 16 bits wide. Each region also has a fixed access length of 2 or 3 clock cycles per narrow transfer. A byte, word or longword request aimed at a region is cut into as many narrow sub-accesses as the region's width needs. The sub-accesses run back to back and in big-endian order. Read data is shifted back into one right-justified 32-bit result.

The whole run of sub-accesses counts as one indivisible bus cycle. An outside requester that asks for the bus while a run is in progress waits until the run's final cycle is over. It is granted in the first idle cycle after that. Instruction fetches always move a full aligned longword, whatever the width of the region.

Top module: `narrow_bus_splitter`

## Requirements
- R1: The region is chosen by address bits [29:28] (default `REGION_LSB` = 28). By default, region 0 is 8-bit with 2 cycles, region 1 is 16-bit with 2 cycles, region 2 is 8-bit with 3 cycles, and region 3 is 16-bit with 3 cycles. Each sub-access holds `sub_valid` high and keeps `sub_addr` steady for exactly that many consecutive cycles.
- R2: `req_size` is coded 00 = byte, 01 = word, and 10 or 11 = longword. The number of sub-accesses per request depends on the size and the region:
  - longword to an 8-bit region: 4 sub-accesses
  - longword to a 16-bit region: 2 sub-accesses
  - word to an 8-bit region: 2 sub-accesses
  - word to a 16-bit region: 1 sub-access
  - any byte: 1 sub-access, with `sub_wide` = 0
- R3: The first sub-access uses the aligned request address. Each later sub-access adds the sub-access width in bytes: 1 when `sub_wide` = 0, 2 when `sub_wide` = 1.
- R4: On writes, the first sub-access carries the most significant used byte or halfword of the right-justified `req_wdata`. A halfword uses `sub_wdata[15:0]`. A byte uses `sub_wdata[7:0]`, with `sub_wdata[15:8]` = 0.
- R5: `sub_rdata` is sampled in the last cycle of each sub-access. It comes from `[7:0]` for a byte and `[15:0]` for a halfword. The first sample ends up most significant, and `rdata` is right-justified to the request size.
- R6: `done` is high for exactly one cycle: the cycle right after the last sub-access cycle. On reads, the assembled `rdata` is valid in that same cycle.
- R7: With `req_fetch` = 1, the request is a longword read at the address rounded down to a multiple of 4, whatever the values of `req_size` and `req_addr[1:0]`.
- R8: A data request whose address is not aligned to its size starts at the address rounded down to that size.
- R9: `bus_locked` is high in every sub-access cycle and low in the `done` cycle. `ext_bgrant` is never high while `bus_locked` is high.
- R10: When `ext_breq` is held during a locked run, `ext_bgrant` rises in the first cycle after the lock ends. In idle, `ext_bgrant` rises one cycle after `ext_breq` and falls one cycle after `ext_breq` drops. While `ext_breq` or `ext_bgrant` is high, `req_ready` is low and no master request is taken.
- R11: After reset, these outputs are low: `sub_valid`, `bus_locked`, `done`, `ext_bgrant` and `rdata`. `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Master request strobe |
| req_ready | output | 1 | Request is taken when high together with req_valid |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | 00 byte, 01 word, 1x longword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Instruction fetch (forces aligned longword read) |
| req_wdata | input | 32 | Right-justified write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled right-justified read data |
| sub_valid | output | 1 | Narrow sub-access in progress |
| sub_addr | output | 32 | Sub-access byte address |
| sub_write | output | 1 | Sub-access direction |
| sub_wide | output | 1 | 1 = 16-bit sub-access, 0 = 8-bit |
| sub_wdata | output | 16 | Sub-access write data |
| sub_rdata | input | 16 | Sub-access read data from the slave |
| ext_breq | input | 1 | Bus request from another master |
| ext_bgrant | output | 1 | Bus granted to the other master |
| bus_locked | output | 1 | Indivisible bus cycle in progress |

## Verification
The first sub-access appears in the cycle after the clock edge that takes the request. Every sub-access then lasts the region's 2 or 3 cycles. `done` and the assembled data follow one cycle after the final sub-access cycle. The grant follows one cycle after `ext_breq` is seen in idle, or in the first cycle after a locked run when the request arrived during the run. The bench drives inputs and samples outputs on falling edges. It walks the expected schedule one cycle at a time and checks the address, width, data, lock and grant at each of those points, so a result that arrives one cycle early or late is reported.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int BUS_W    = 32;
    localparam int NARROW_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LALT = 2'b11
    } xfer_size_e;

endpackage

// File: rtl/nbs_region_decode.sv
module nbs_region_decode #(
    parameter int                     NUM_REGIONS = 4,
    parameter logic [NUM_REGIONS-1:0] REGION_IS16 = 4'b1010,
    parameter logic [NUM_REGIONS-1:0] REGION_CYC3 = 4'b1100,
    localparam int                    RIDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic [RIDX_W-1:0] region_idx,
    output logic              reg_is16,
    output logic              reg_cyc3
);

    logic [NUM_REGIONS-1:0] hit;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_hit
        assign hit[g] = (region_idx == RIDX_W'(g));
    end

    assign reg_is16 = |(hit & REGION_IS16);
    assign reg_cyc3 = |(hit & REGION_CYC3);

endmodule

// File: rtl/nbs_bus_arbiter.sv
module nbs_bus_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_breq,
    input  logic locked,
    input  logic lock_ending,
    output logic ext_bgrant,
    output logic master_ok
);

    typedef struct packed {
        logic grant;
    } arb_t;

    arb_t a_d, a_q;

    always_comb begin
        a_d       = a_q;
        a_d.grant = ext_breq && (!locked || lock_ending);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign ext_bgrant = a_q.grant;
    assign master_ok  = !ext_breq && !a_q.grant;

    assert_no_grant_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !a_q.grant);

    assert_grant_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_q.grant) |-> $past(ext_breq));

    assert_grant_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.grant && !ext_breq) |=> !a_q.grant);

endmodule

// File: rtl/nbs_sequencer.sv
module nbs_sequencer
    import nbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic                req_fetch,
    input  logic [BUS_W-1:0]    req_wdata,
    input  logic                reg_is16,
    input  logic                reg_cyc3,
    input  logic [NARROW_W-1:0] sub_rdata,
    output logic                busy,
    output logic                lock_ending,
    output logic [ADDR_W-1:0]   sub_addr,
    output logic                sub_wide,
    output logic                sub_write,
    output logic [NARROW_W-1:0] sub_wdata,
    output logic                done,
    output logic [BUS_W-1:0]    rdata
);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic              wide;
        logic              cyc3;
        logic              write;
        logic [1:0]        cnt;
        logic [1:0]        left;
        logic [BUS_W-1:0]  wsh;
        logic [BUS_W-1:0]  acc;
        logic              done;
        logic [BUS_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    xfer_size_e       eff_size;
    logic             wide_new;
    logic             sub_end;
    logic [BUS_W-1:0] acc_next;

    always_comb begin
        // fetches and the spare code both mean longword
        if (req_fetch || req_size == SZ_LALT) eff_size = SZ_LONG;
        else                                  eff_size = xfer_size_e'(req_size);
        wide_new = reg_is16 && (eff_size != SZ_BYTE);
        sub_end  = (s_q.cnt == (s_q.cyc3 ? 2'd2 : 2'd1));
        acc_next = s_q.wide ? {s_q.acc[15:0], sub_rdata}
                            : {s_q.acc[23:0], sub_rdata[7:0]};

        s_d      = s_q;
        s_d.done = 1'b0;

        if (!s_q.busy) begin
            if (accept) begin
                s_d.busy  = 1'b1;
                s_d.wide  = wide_new;
                s_d.cyc3  = reg_cyc3;
                s_d.write = req_write && !req_fetch;
                s_d.cnt   = 2'd0;
                s_d.acc   = '0;
                case (eff_size)
                    SZ_BYTE: begin
                        s_d.addr = req_addr;
                        s_d.left = 2'd0;
                        s_d.wsh  = {req_wdata[7:0], 24'h0};
                    end
                    SZ_WORD: begin
                        s_d.addr = {req_addr[ADDR_W-1:1], 1'b0};
                        s_d.left = wide_new ? 2'd0 : 2'd1;
                        s_d.wsh  = {req_wdata[15:0], 16'h0};
                    end
                    default: begin
                        s_d.addr = {req_addr[ADDR_W-1:2], 2'b00};
                        s_d.left = wide_new ? 2'd1 : 2'd3;
                        s_d.wsh  = req_wdata;
                    end
                endcase
            end
        end else if (sub_end) begin
            s_d.acc = acc_next;
            s_d.cnt = 2'd0;
            if (s_q.left == 2'd0) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.rdata = acc_next;
            end else begin
                s_d.left = s_q.left - 2'd1;
                s_d.addr = s_q.addr + {{(ADDR_W-2){1'b0}}, s_q.wide, !s_q.wide};
                s_d.wsh  = s_q.wide ? {s_q.wsh[15:0], 16'h0} : {s_q.wsh[23:0], 8'h0};
            end
        end else begin
            s_d.cnt = s_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy        = s_q.busy;
    assign lock_ending = s_q.busy && sub_end && (s_q.left == 2'd0);
    assign sub_addr    = s_q.addr;
    assign sub_wide    = s_q.wide;
    assign sub_write   = s_q.write;
    assign sub_wdata   = s_q.wide ? s_q.wsh[31:16] : {8'h00, s_q.wsh[31:24]};
    assign done        = s_q.done;
    assign rdata       = s_q.rdata;

    assert_hold_sub_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !sub_end) |=> (s_q.busy && $stable(s_q.addr)));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && sub_end && s_q.left != 2'd0) |=>
            (s_q.addr == $past(s_q.addr) + (s_q.wide ? 2 : 1)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> ($past(s_q.busy) && !s_q.busy));

endmodule

// File: rtl/narrow_bus_splitter.sv
module narrow_bus_splitter
    import nbs_pkg::*;
#(
    parameter int                     ADDR_W      = 32,
    parameter int                     NUM_REGIONS = 4,
    parameter int                     REGION_LSB  = 28,
    parameter logic [NUM_REGIONS-1:0] REGION_IS16 = 4'b1010,
    parameter logic [NUM_REGIONS-1:0] REGION_CYC3 = 4'b1100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic                req_fetch,
    input  logic [BUS_W-1:0]    req_wdata,
    output logic                done,
    output logic [BUS_W-1:0]    rdata,
    output logic                sub_valid,
    output logic [ADDR_W-1:0]   sub_addr,
    output logic                sub_write,
    output logic                sub_wide,
    output logic [NARROW_W-1:0] sub_wdata,
    input  logic [NARROW_W-1:0] sub_rdata,
    input  logic                ext_breq,
    output logic                ext_bgrant,
    output logic                bus_locked
);

    localparam int RIDX_W = $clog2(NUM_REGIONS);

    logic reg_is16, reg_cyc3;
    logic busy, lock_ending, master_ok, accept;

    assign req_ready  = !busy && master_ok;
    assign accept     = req_valid && req_ready;
    assign sub_valid  = busy;
    assign bus_locked = busy;

    nbs_region_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .REGION_IS16 (REGION_IS16),
        .REGION_CYC3 (REGION_CYC3)
    ) decode_i (
        .region_idx (req_addr[REGION_LSB +: RIDX_W]),
        .reg_is16   (reg_is16),
        .reg_cyc3   (reg_cyc3)
    );

    nbs_sequencer #(
        .ADDR_W (ADDR_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .req_fetch   (req_fetch),
        .req_wdata   (req_wdata),
        .reg_is16    (reg_is16),
        .reg_cyc3    (reg_cyc3),
        .sub_rdata   (sub_rdata),
        .busy        (busy),
        .lock_ending (lock_ending),
        .sub_addr    (sub_addr),
        .sub_wide    (sub_wide),
        .sub_write   (sub_write),
        .sub_wdata   (sub_wdata),
        .done        (done),
        .rdata       (rdata)
    );

    nbs_bus_arbiter arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_breq    (ext_breq),
        .locked      (busy),
        .lock_ending (lock_ending),
        .ext_bgrant  (ext_bgrant),
        .master_ok   (master_ok)
    );

    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> sub_valid);

    assert_no_take_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bgrant || ext_breq) |-> !accept);

endmodule

// File: tb/narrow_bus_splitter_tb_top.sv
module narrow_bus_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        sub_valid;
    logic [31:0] sub_addr;
    logic        sub_write;
    logic        sub_wide;
    logic [15:0] sub_wdata;
    logic [15:0] sub_rdata = '0;
    logic        ext_breq = 1'b0;
    logic        ext_bgrant;
    logic        bus_locked;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    narrow_bus_splitter dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .req_size (req_size), .req_write (req_write), .req_fetch (req_fetch),
        .req_wdata (req_wdata), .done (done), .rdata (rdata),
        .sub_valid (sub_valid), .sub_addr (sub_addr), .sub_write (sub_write),
        .sub_wide (sub_wide), .sub_wdata (sub_wdata), .sub_rdata (sub_rdata),
        .ext_breq (ext_breq), .ext_bgrant (ext_bgrant), .bus_locked (bus_locked)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] slave_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h3C ^ {a[29:28], 6'h0};
    endfunction

    // runs one request and checks every cycle of the expected schedule
    task automatic run_xfer(input string tag, input logic [31:0] addr, input logic [1:0] size,
                            input logic wr, input logic fetch, input logic [31:0] wdata,
                            input int breq_cycle);
        int eff, nbytes, rg, cyc, w, nsub, idx;
        bit is16;
        logic [31:0] abase, wd_be, exp_rd, sh;
        eff    = fetch ? 2 : ((size == 2'b11) ? 2 : int'(size));
        nbytes = 1 << eff;
        abase  = addr & ~(32'(nbytes) - 32'd1);
        rg     = int'(addr[29:28]);
        is16   = (rg == 1) || (rg == 3);
        cyc    = (rg >= 2) ? 3 : 2;
        w      = (is16 && nbytes > 1) ? 2 : 1;
        nsub   = nbytes / w;
        exp_rd = '0;
        for (int j = 0; j < nbytes; j++) exp_rd = (exp_rd << 8) | 32'(slave_byte(abase + 32'(j)));
        wd_be  = wdata << ((4 - nbytes) * 8);

        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 ready before request"}, 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = addr; req_size = size;
        req_write = wr; req_fetch = fetch; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        idx = 0;
        for (int k = 0; k < nsub; k++) begin
            logic [31:0] a;
            a  = abase + 32'(k * w);
            sh = wd_be << (k * w * 8);
            for (int c = 0; c < cyc; c++) begin
                if (idx == breq_cycle) ext_breq = 1'b1;
                sub_rdata = (w == 2) ? {slave_byte(a), slave_byte(a + 32'd1)} : {8'h00, slave_byte(a)};
                chk(sub_valid == 1'b1, {tag, " R1 sub_valid held"}, 32'(sub_valid), 1);
                chk(sub_addr == a, {tag, " R3 sub_addr"}, sub_addr, a);
                chk(sub_wide == (w == 2), {tag, " R2 sub_wide"}, 32'(sub_wide), 32'(w == 2));
                chk(sub_write == wr, {tag, " R4 sub_write"}, 32'(sub_write), 32'(wr));
                if (wr) chk(sub_wdata == ((w == 2) ? sh[31:16] : {8'h00, sh[31:24]}),
                            {tag, " R4 sub_wdata"}, 32'(sub_wdata),
                            32'((w == 2) ? sh[31:16] : {8'h00, sh[31:24]}));
                chk(bus_locked == 1'b1, {tag, " R9 locked in run"}, 32'(bus_locked), 1);
                chk(ext_bgrant == 1'b0, {tag, " R9 no grant in run"}, 32'(ext_bgrant), 0);
                chk(done == 1'b0, {tag, " R6 no early done"}, 32'(done), 0);
                @(negedge clk);
                idx++;
            end
        end
        chk(done == 1'b1, {tag, " R6 done after last sub"}, 32'(done), 1);
        chk(sub_valid == 1'b0, {tag, " R2 sub count"}, 32'(sub_valid), 0);
        chk(bus_locked == 1'b0, {tag, " R9 lock ends"}, 32'(bus_locked), 0);
        if (!wr) chk(rdata == exp_rd, {tag, " R5 rdata"}, rdata, exp_rd);
        chk(ext_bgrant == (breq_cycle >= 0), {tag, " R10 grant after lock"},
            32'(ext_bgrant), 32'(breq_cycle >= 0));
        ext_breq = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done is one cycle"}, 32'(done), 0);
        chk(ext_bgrant == 1'b0, {tag, " R10 grant drops"}, 32'(ext_bgrant), 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 1);
        chk(sub_valid == 1'b0, "R11 sub_valid", 32'(sub_valid), 0);
        chk(bus_locked == 1'b0, "R11 bus_locked", 32'(bus_locked), 0);
        chk(done == 1'b0, "R11 done", 32'(done), 0);
        chk(ext_bgrant == 1'b0, "R11 ext_bgrant", 32'(ext_bgrant), 0);
        chk(rdata == 32'h0, "R11 rdata", rdata, 0);
    endtask

    task automatic t_long_read_8bit();   // R2 four subs, R9 eight locked cycles
        run_xfer("long read 8b/2cyc", 32'h0000_0100, 2'b10, 1'b0, 1'b0, '0, -1);
    endtask

    task automatic t_long_write_16bit(); // R4 halfword lanes
        run_xfer("long write 16b/2cyc", 32'h1000_0208, 2'b11, 1'b1, 1'b0, 32'hA1B2_C3D4, -1);
    endtask

    task automatic t_word_read_misaligned(); // R8 rounding down, R1 3-cycle
        run_xfer("R8 word read odd addr 8b/3cyc", 32'h2000_0013, 2'b01, 1'b0, 1'b0, '0, -1);
    endtask

    task automatic t_byte_write_16bit(); // R2 byte stays narrow
        run_xfer("byte write 16b/3cyc", 32'h3000_0045, 2'b00, 1'b1, 1'b0, 32'hFFFF_FF9E, -1);
    endtask

    task automatic t_word_read_16bit();
        run_xfer("word read 16b/3cyc", 32'h3000_0082, 2'b01, 1'b0, 1'b0, '0, -1);
    endtask

    task automatic t_word_write_8bit();
        run_xfer("word write 8b/2cyc", 32'h0000_0030, 2'b01, 1'b1, 1'b0, 32'h0000_5AC3, -1);
    endtask

    task automatic t_fetch_odd_word();   // R7 odd-word fetch reads whole longword
        run_xfer("R7 fetch odd word", 32'h0000_0406, 2'b01, 1'b0, 1'b1, '0, -1);
    endtask

    task automatic t_fetch_even_word();  // R7 size ignored for fetches
        run_xfer("R7 fetch even word", 32'h1000_0600, 2'b00, 1'b0, 1'b1, '0, -1);
    endtask

    task automatic t_breq_during_lock(); // R10 pending request granted after lock
        run_xfer("R10 breq mid-run", 32'h2000_0040, 2'b10, 1'b0, 1'b0, '0, 3);
    endtask

    task automatic t_breq_idle();        // R10 idle grant and master blocked
        @(negedge clk);
        ext_breq = 1'b1;
        req_valid = 1'b1; req_addr = 32'h0000_0010; req_size = 2'b00;
        req_write = 1'b0; req_fetch = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R10 ready low on breq", 32'(req_ready), 0);
        @(negedge clk);
        chk(ext_bgrant == 1'b1, "R10 idle grant", 32'(ext_bgrant), 1);
        chk(sub_valid == 1'b0, "R10 master not taken", 32'(sub_valid), 0);
        @(negedge clk);
        chk(sub_valid == 1'b0, "R10 master still held off", 32'(sub_valid), 0);
        chk(req_ready == 1'b0, "R10 ready low while granted", 32'(req_ready), 0);
        ext_breq = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(ext_bgrant == 1'b0, "R10 grant released", 32'(ext_bgrant), 0);
        chk(req_ready == 1'b1, "R10 ready returns", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_read_8bit();
        t_long_write_16bit();
        t_word_read_misaligned();
        t_byte_write_16bit();
        t_word_read_16bit();
        t_word_write_8bit();
        t_fetch_odd_word();
        t_fetch_even_word();
        t_breq_during_lock();
        t_breq_idle();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule